// File: doc/BRIEF.md
# Interrupt Source Steering Matrix

This block takes a fixed set of interrupt sources and places each one on any of sixteen interrupt request lines. There are four bus interrupt pins, a parameterised number of timer outputs and a parameterised number of general-purpose inputs. Each source has a byte-wide map register. The register holds either a line number or a reserved code that turns the source off. Several sources may share one line, and their contributions are ORed together.

Every source input passes through a two-flop synchroniser. The general-purpose inputs can then be inverted, one polarity bit per input. The bus pins and timer outputs have no polarity control. Each line is either level or edge triggered. In level mode the line follows its combined input. In edge mode a rising edge of the combined input sets a pending bit, and that bit holds until software clears it. The map, trigger and polarity registers are reached through a simple byte-wide write/read port.

Top module: `irq_steer_matrix`

## Requirements
- R1: After reset every map register reads 0xFF (source off), the trigger and polarity registers read 0, and all sixteen request lines are low.
- R2: A map write is stored only when the value is 0..15 or 0xFF. Any other value leaves the register unchanged. Map register k is at address k, with bus pins at 0..3, timers next and general-purpose inputs after them. Reads return the stored value.
- R3: When a source is mapped to line n and that line is level-triggered, an active source drives exactly request line n high.
- R4: When several enabled sources map to the same line, that line is the OR of their conditioned inputs.
- R5: Remapping a source to 0xFF stops it from driving its former line, even while its input stays active.
- R6: In edge mode a rising edge of the combined input sets the line. The line stays set after the input falls, until a 1 is written to its clear bit. Clear bits are at 0x24 for lines 0..7 and 0x25 for lines 8..15, with bit = line mod 8. An input held high after a clear does not set the line again.
- R7: Trigger bits are at 0x20 for lines 0..7 and 0x21 for lines 8..15, with bit = line mod 8. A 1 selects level mode, and the line then follows the combined input directly.
- R8: Polarity bit n inverts general-purpose input n. Bits for inputs 0..7 are at 0x22 and bits for inputs 8..10 are at 0x23 bits 0..2. Bus pins and timer outputs are never inverted.
- R9: A change on a source input reaches the request line on the third rising clock edge after it is applied.
- R10: The trigger and polarity registers read back as written. Polarity bits with no matching input read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_int | input | 4 | Bus interrupt pins, active high |
| tmr_in | input | N_TMR | Timer interrupt outputs |
| gp_in | input | N_GP | General-purpose interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for addr (combinational) |
| irq_out | output | 16 | Conditioned interrupt request lines |

## Verification
The assertions check the following on every cycle:
- An illegal map write leaves that map register unchanged.
- In edge mode, a rising combined input sets the line on the next cycle.
- A pending edge holds until its clear bit is written.
- In level mode, an idle combined input forces the line low on the next cycle.

The routing of each source to each line, OR-combining, the effect of disabling a source, polarity only on general-purpose inputs, and the three-edge latency can only be shown by the bench's sweeps and scenarios. These are checked at the request-line outputs.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
    localparam int          LINES     = 16;
    localparam logic [7:0]  MAP_OFF   = 8'hFF;
    localparam logic [5:0]  A_TRIG_LO = 6'h20;
    localparam logic [5:0]  A_TRIG_HI = 6'h21;
    localparam logic [5:0]  A_POL_LO  = 6'h22;
    localparam logic [5:0]  A_POL_HI  = 6'h23;
    localparam logic [5:0]  A_CLR_LO  = 6'h24;
    localparam logic [5:0]  A_CLR_HI  = 6'h25;

    // A map value is accepted if it names a line or is the off code
    function automatic logic map_ok(input logic [7:0] v);
        return (v < 8'(LINES)) || (v == MAP_OFF);
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.s2;
endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs
    import irq_steer_pkg::*;
#(
    parameter int NSRC = 18,
    parameter int NGP  = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [5:0]           addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic [NSRC-1:0][7:0] map_o,
    output logic [LINES-1:0]     lvl_o,
    output logic [NGP-1:0]       pol_o,
    output logic [LINES-1:0]     clr_o
);
    localparam logic [15:0] POL_MASK = (NGP >= 16) ? 16'hFFFF : 16'((32'd1 << NGP) - 32'd1);

    typedef struct packed {
        logic [NSRC-1:0][7:0] map;
        logic [LINES-1:0]     lvl;
        logic [15:0]          pol;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        clr_o  = '0;
        if (wr_en) begin
            for (int i = 0; i < NSRC; i++) begin
                if (addr == 6'(i) && map_ok(wdata)) regs_d.map[i] = wdata;
            end
            case (addr)
                A_TRIG_LO: regs_d.lvl[7:0]  = wdata;
                A_TRIG_HI: regs_d.lvl[15:8] = wdata;
                A_POL_LO:  regs_d.pol[7:0]  = wdata & POL_MASK[7:0];
                A_POL_HI:  regs_d.pol[15:8] = wdata & POL_MASK[15:8];
                A_CLR_LO:  clr_o[7:0]       = wdata;
                A_CLR_HI:  clr_o[15:8]      = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (addr == 6'(i)) rdata = regs_q.map[i];
        end
        case (addr)
            A_TRIG_LO: rdata = regs_q.lvl[7:0];
            A_TRIG_HI: rdata = regs_q.lvl[15:8];
            A_POL_LO:  rdata = regs_q.pol[7:0];
            A_POL_HI:  rdata = regs_q.pol[15:8];
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.map <= {NSRC{MAP_OFF}};
            regs_q.lvl <= '0;
            regs_q.pol <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign map_o = regs_q.map;
    assign lvl_o = regs_q.lvl;
    assign pol_o = regs_q.pol[NGP-1:0];

    for (genvar g = 0; g < NSRC; g++) begin : g_map_chk
        AST_ILLEGAL_MAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == 6'(g) && !map_ok(wdata)) |=> $stable(regs_q.map[g])); // R2
    end
endmodule

// File: rtl/irq_line_cond.sv
module irq_line_cond
    import irq_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] comb_i,
    input  logic [LINES-1:0] lvl_i,
    input  logic [LINES-1:0] clr_i,
    output logic [LINES-1:0] irq_o
);
    typedef struct packed {
        logic [LINES-1:0] prev;
        logic [LINES-1:0] pend;
        logic [LINES-1:0] irq;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d      = line_q;
        line_d.prev = comb_i;
        // a new rising edge wins over a clear in the same cycle
        line_d.pend = (line_q.pend & ~clr_i) | (comb_i & ~line_q.prev);
        line_d.irq  = (lvl_i & comb_i) | (~lvl_i & line_d.pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign irq_o = line_q.irq;

    for (genvar l = 0; l < LINES; l++) begin : g_line_chk
        AST_EDGE_SETS_LINE: assert property (@(posedge clk) disable iff (!rst_n) (!lvl_i[l] && comb_i[l] && !line_q.prev[l]) |=> irq_o[l]); // R6
        AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!lvl_i[l] && line_q.pend[l] && !clr_i[l]) |=> irq_o[l]); // R6
        AST_LEVEL_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) (lvl_i[l] && !comb_i[l]) |=> !irq_o[l]); // R7
    end
endmodule

// File: rtl/irq_steer_matrix.sv
module irq_steer_matrix
    import irq_steer_pkg::*;
#(
    parameter int N_BUS = 4,
    parameter int N_TMR = 3,
    parameter int N_GP  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BUS-1:0]  bus_int,
    input  logic [N_TMR-1:0]  tmr_in,
    input  logic [N_GP-1:0]   gp_in,
    input  logic              wr_en,
    input  logic [5:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [LINES-1:0]  irq_out
);
    localparam int NSRC    = N_BUS + N_TMR + N_GP;
    localparam int GP_BASE = N_BUS + N_TMR;

    logic [NSRC-1:0]      raw_src;
    logic [NSRC-1:0]      sync_src;
    logic [NSRC-1:0]      cond_src;
    logic [NSRC-1:0][7:0] map_w;
    logic [LINES-1:0]     lvl_w;
    logic [N_GP-1:0]      pol_w;
    logic [LINES-1:0]     clr_w;
    logic [LINES-1:0]     comb_w;

    assign raw_src = {gp_in, tmr_in, bus_int};

    irq_sync #(.W(NSRC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_src),
        .dout (sync_src)
    );

    irq_map_regs #(.NSRC(NSRC), .NGP(N_GP)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata),
        .map_o(map_w),
        .lvl_o(lvl_w),
        .pol_o(pol_w),
        .clr_o(clr_w)
    );

    // polarity only touches the general-purpose slice
    always_comb begin
        cond_src = sync_src;
        cond_src[GP_BASE +: N_GP] = sync_src[GP_BASE +: N_GP] ^ pol_w;
    end

    always_comb begin
        comb_w = '0;
        for (int l = 0; l < LINES; l++) begin
            for (int s = 0; s < NSRC; s++) begin
                if (map_w[s] == 8'(l)) comb_w[l] = comb_w[l] | cond_src[s];
            end
        end
    end

    irq_line_cond u_lines (
        .clk   (clk),
        .rst_n (rst_n),
        .comb_i(comb_w),
        .lvl_i (lvl_w),
        .clr_i (clr_w),
        .irq_o (irq_out)
    );
endmodule

// File: tb/irq_steer_matrix_tb_top.sv
module irq_steer_matrix_tb_top;
    localparam int NSRC = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NSRC-1:0] srcv = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] irq_out;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_steer_matrix dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_int(srcv[3:0]), .tmr_in(srcv[6:4]), .gp_in(srcv[17:7]),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, {8'h00, rdata}, {8'h00, exp});
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", irq_out, 16'h0000);
        for (int i = 0; i < NSRC; i++) rd_chk("R1 map", 6'(i), 8'hFF);
        rd_chk("R1 trig", 6'h20, 8'h00);
        rd_chk("R1 trig", 6'h21, 8'h00);
        rd_chk("R1 pol", 6'h22, 8'h00);
        rd_chk("R1 pol", 6'h23, 8'h00);

        // R2 legal and illegal map values
        wr(6'd0, 8'd5);   rd_chk("R2 legal", 6'd0, 8'd5);
        wr(6'd0, 8'h20);  rd_chk("R2 illegal", 6'd0, 8'd5);
        wr(6'd0, 8'd16);  rd_chk("R2 illegal", 6'd0, 8'd5);
        wr(6'd0, 8'hFF);  rd_chk("R2 off", 6'd0, 8'hFF);

        // R7 level mode for all lines, R10 readback
        wr(6'h20, 8'hFF); wr(6'h21, 8'hFF);
        rd_chk("R10 trig", 6'h21, 8'hFF);

        // R9 latency
        wr(6'd0, 8'd0);
        @(negedge clk); srcv[0] = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R9 early", irq_out, 16'h0000);
        @(posedge clk); @(negedge clk);
        chk("R9 third edge", irq_out, 16'h0001);
        srcv[0] = 1'b0; wr(6'd0, 8'hFF); settle();
        chk("R7 follows low", irq_out, 16'h0000);

        // R3 sweep: every source onto every line
        for (int s = 0; s < NSRC; s++) begin
            for (int l = 0; l < 16; l++) begin
                wr(6'(s), 8'(l));
                srcv[s] = 1'b1;
                settle();
                chk("R3 route", irq_out, 16'(32'd1 << l));
                srcv[s] = 1'b0;
                wr(6'(s), 8'hFF);
            end
        end
        settle();

        // R4 OR of two sources on line 3
        wr(6'd0, 8'd3); wr(6'd7, 8'd3);
        srcv[7] = 1'b1; settle(); chk("R4 gp only", irq_out, 16'h0008);
        srcv[7] = 1'b0; srcv[0] = 1'b1; settle(); chk("R4 bus only", irq_out, 16'h0008);
        srcv[7] = 1'b1; settle(); chk("R4 both", irq_out, 16'h0008);
        srcv[7] = 1'b0; srcv[0] = 1'b0; settle(); chk("R4 none", irq_out, 16'h0000);
        wr(6'd0, 8'hFF); wr(6'd7, 8'hFF);

        // R5 disable while active
        wr(6'd1, 8'd9); srcv[1] = 1'b1; settle();
        chk("R5 active", irq_out, 16'h0200);
        wr(6'd1, 8'hFF); settle();
        chk("R5 disabled", irq_out, 16'h0000);
        srcv[1] = 1'b0;

        // R6 edge mode: clear anything left pending, then pulse
        wr(6'h20, 8'h00); wr(6'h21, 8'h00);
        wr(6'h24, 8'hFF); wr(6'h25, 8'hFF);
        settle();
        chk("R6 cleared", irq_out, 16'h0000);
        wr(6'd2, 8'd12);
        srcv[2] = 1'b1; settle(); chk("R6 set", irq_out, 16'h1000);
        srcv[2] = 1'b0; settle(); chk("R6 held", irq_out, 16'h1000);
        wr(6'h25, 8'h01); chk("R6 other clear", irq_out, 16'h1000);
        wr(6'h25, 8'h10); chk("R6 clear", irq_out, 16'h0000);
        srcv[2] = 1'b1; settle(); chk("R6 reset", irq_out, 16'h1000);
        wr(6'h25, 8'h10); settle(); chk("R6 no retrigger", irq_out, 16'h0000);
        srcv[2] = 1'b0; wr(6'd2, 8'hFF); settle();

        // R8 polarity, level mode
        wr(6'h20, 8'hFF);
        wr(6'd7, 8'd1); wr(6'h22, 8'h01); settle();
        chk("R8 gp0 inverted", irq_out, 16'h0002);
        srcv[7] = 1'b1; settle();
        chk("R8 gp0 active", irq_out, 16'h0000);
        wr(6'd17, 8'd2); wr(6'h23, 8'h04); settle();
        chk("R8 gp10 inverted", irq_out, 16'h0004);
        wr(6'd0, 8'd4); wr(6'h22, 8'hFF); settle();
        chk("R8 bus not inverted", irq_out, 16'h0004);
        srcv[0] = 1'b1; settle();
        chk("R8 bus active", irq_out, 16'h0014);

        // R10 polarity readback masking
        wr(6'h23, 8'hFF); rd_chk("R10 pol hi", 6'h23, 8'h07);
        rd_chk("R10 pol lo", 6'h22, 8'hFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule